// File: doc/BRIEF.md
# Compare and Action Qualifier Unit

This block sits after a time-base counter and turns the counter's state into two pulse-width outputs. Each clock where the counter advances (the `tick` strobe), it looks at the counter value, the counting direction and the zero and period strobes. From these it finds up to six events: zero, period, compare A while counting up or down, and compare B while counting up or down. For each output, a 12-bit action word gives one 2-bit action per event. The action can hold the output, drive it low, drive it high or toggle it.

There are two compare registers. Each one has its own write port and its own choice of write mode. In immediate mode a write takes effect at once. In shadow mode a write waits in a shadow register. It is copied into the active register at a selectable point in the cycle: on a zero match, on a period match, on either, or never. Each output also has a continuous 2-bit force control. While the force is asserted, it pins the output high or low and overrides every event.

Top module: `cmp_aq_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs go to 0 and both active compare values go to 0.
- R2: An action code of 0 leaves the output unchanged. Code 1 drives it low, code 2 drives it high and code 3 inverts it. The change shows at the clock edge that samples the event.
- R3: The action word carries one action code per event at these bit positions: [1:0] zero, [3:2] period, [5:4] compare A counting up, [7:6] compare A counting down, [9:8] compare B counting up, [11:10] compare B counting down.
- R4: A compare event happens only on a `tick` where `cnt` equals the active compare value. It is qualified by `cnt_up` at that same tick (1 means up, 0 means down).
- R5: When several events with nonzero action codes occur on one tick, compare B wins over compare A, compare A wins over period, and period wins over zero. An event whose code is 0 does not block events of lower priority.
- R6: In immediate mode (mode bit 1), a write sets the active compare value at the next clock edge.
- R7: In shadow mode (mode bit 0), a write only updates the shadow register. The active value is reloaded from the shadow on a tick according to the reload field: 0 reloads on a zero strobe, 1 on a period strobe, 2 on either, and 3 never reloads.
- R8: Compare A and compare B each have their own write port, mode bit and reload field, and neither affects the other.
- R9: Force code 1 drives the output low and force code 2 drives it high, at every clock edge, overriding all events. Codes 0 and 3 apply no force. After a force is released, the output keeps the forced level until the next event.
- R10: Output A and output B each have their own action word and force code, and each responds only to its own.
- R11: Strobes and compare equalities seen without `tick` cause no action and no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter advance strobe; qualifies all events |
| cnt | input | CNT_W | Counter value |
| cnt_up | input | 1 | Counting direction, 1 = up |
| at_zero | input | 1 | Counter is at zero |
| at_period | input | 1 | Counter is at period |
| cmpa_wr_en | input | 1 | Compare A write strobe |
| cmpa_wr_data | input | CNT_W | Compare A write value |
| cmpa_imm | input | 1 | Compare A mode: 1 immediate, 0 shadow |
| cmpa_ld_sel | input | 2 | Compare A reload point |
| cmpb_wr_en | input | 1 | Compare B write strobe |
| cmpb_wr_data | input | CNT_W | Compare B write value |
| cmpb_imm | input | 1 | Compare B mode: 1 immediate, 0 shadow |
| cmpb_ld_sel | input | 2 | Compare B reload point |
| act_a | input | 12 | Action word for output A |
| act_b | input | 12 | Action word for output B |
| frc_a | input | 2 | Continuous force for output A |
| frc_b | input | 2 | Continuous force for output B |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cmpa_cur | output | CNT_W | Active compare A value |
| cmpb_cur | output | CNT_W | Active compare B value |

## Verification
The bench checks that compare matches respect direction. A design that ignores `cnt_up` would fire the up-count action on a down-count match. It steps a shadow-mode write through all four reload choices. A design that mixes up the reload encoding would take the new value at the wrong strobe, or take it while reloading is disabled. It stacks compare B, compare A, period and zero on one tick, including a compare B event with code 0. A design with the priority reversed, or one that lets a zero code block lower events, would produce the wrong level. It also checks that a released force leaves the forced level in place, and that strobes without `tick` are ignored.

// File: rtl/cmp_aq_pkg.sv
// Shared types for the compare/action unit.
// Assumes: six events per output, 2-bit action codes.
package cmp_aq_pkg;
    localparam int NUM_EVT = 6;
    localparam int ACT_W   = 2 * NUM_EVT;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_INVERT = 2'd3
    } act_code_t;

    typedef enum logic [1:0] {
        LD_ON_ZERO   = 2'd0,
        LD_ON_PERIOD = 2'd1,
        LD_ON_EITHER = 2'd2,
        LD_NEVER     = 2'd3
    } reload_t;

    // Event index order; a higher index has higher priority.
    localparam int EV_ZERO = 0;
    localparam int EV_PRD  = 1;
    localparam int EV_AUP  = 2;
    localparam int EV_ADN  = 3;
    localparam int EV_BUP  = 4;
    localparam int EV_BDN  = 5;

    // Returns the next output level for an action code.
    function automatic logic apply_act(input act_code_t c, input logic cur);
        case (c)
            ACT_LOW:    apply_act = 1'b0;
            ACT_HIGH:   apply_act = 1'b1;
            ACT_INVERT: apply_act = ~cur;
            default:    apply_act = cur;
        endcase
    endfunction
endpackage

// File: rtl/cmp_reg.sv
// One compare register with an active and a shadow copy.
// Immediate mode writes the active copy directly. Shadow mode holds
// the write until the selected reload point.
// Assumes: ld_zero / ld_period are already qualified by the counter tick.
module cmp_reg
    import cmp_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             imm,
    input  logic [1:0]       ld_sel,
    input  logic             ld_zero,
    input  logic             ld_period,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] shadow_q;
    logic             load_pt;

    // Decode the reload point from the reload selector.
    always_comb begin
        case (reload_t'(ld_sel))
            LD_ON_ZERO:   load_pt = ld_zero;
            LD_ON_PERIOD: load_pt = ld_period;
            LD_ON_EITHER: load_pt = ld_zero | ld_period;
            default:      load_pt = 1'b0;
        endcase
    end

    // Capture every write into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (wr_en) shadow_q <= wr_data;
    end

    // Update the active copy from a direct write or from the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)               active <= '0;
        else if (wr_en && imm)    active <= wr_data;
        else if (!imm && load_pt) active <= shadow_q;
    end

    AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && imm) |=> (active == $past(wr_data))); // R6
    AST_NO_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == 2'd3 && !imm) |=> $stable(active)); // R7
    AST_SHADOW_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && ld_sel == 2'd0 && ld_zero) |=> (active == $past(shadow_q))); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ld_zero && !ld_period) |=> $stable(active)); // R11
endmodule

// File: rtl/aq_chan.sv
// Action qualifier for one output.
// Picks the highest-priority event that has a nonzero action code and
// applies that code. A continuous force overrides every event.
// Assumes: evt is already qualified by the counter tick.
module aq_chan
    import cmp_aq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [ACT_W-1:0]   act,
    input  logic [1:0]         frc,
    output logic               out
);
    act_code_t win_code;

    // Choose the winning action; a later (higher) index overrides.
    always_comb begin
        win_code = ACT_HOLD;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (evt[i] && act[2*i +: 2] != 2'd0)
                win_code = act_code_t'(act[2*i +: 2]);
        end
    end

    // Output register: force first, then the winning event.
    always_ff @(posedge clk) begin
        if (!rst_n)            out <= 1'b0;
        else if (frc == 2'd1)  out <= 1'b0;
        else if (frc == 2'd2)  out <= 1'b1;
        else                   out <= apply_act(win_code, out);
    end

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frc == 2'd2) |=> out); // R9
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frc == 2'd1) |=> !out); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0 && frc != 2'd1 && frc != 2'd2) |=> $stable(out)); // R11
endmodule

// File: rtl/cmp_aq_unit.sv
// Compare and action qualifier unit (top).
// Forms the six tick-qualified events from the counter inputs and the
// two active compare values, and drives two qualified outputs.
// Assumes: the counter source asserts tick for one clock per count.
module cmp_aq_unit
    import cmp_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic             at_zero,
    input  logic             at_period,
    input  logic             cmpa_wr_en,
    input  logic [CNT_W-1:0] cmpa_wr_data,
    input  logic             cmpa_imm,
    input  logic [1:0]       cmpa_ld_sel,
    input  logic             cmpb_wr_en,
    input  logic [CNT_W-1:0] cmpb_wr_data,
    input  logic             cmpb_imm,
    input  logic [1:0]       cmpb_ld_sel,
    input  logic [11:0]      act_a,
    input  logic [11:0]      act_b,
    input  logic [1:0]       frc_a,
    input  logic [1:0]       frc_b,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [CNT_W-1:0] cmpa_cur,
    output logic [CNT_W-1:0] cmpb_cur
);
    localparam int NUM_CMP = 2;
    localparam int NUM_OUT = 2;

    logic               z_tk, p_tk;
    logic [CNT_W-1:0]   cmp_act [NUM_CMP];
    logic [NUM_CMP-1:0] wr_en_v, imm_v;
    logic [CNT_W-1:0]   wr_d_v  [NUM_CMP];
    logic [1:0]         ld_v    [NUM_CMP];
    logic [NUM_EVT-1:0] evt;
    logic [ACT_W-1:0]   act_v   [NUM_OUT];
    logic [1:0]         frc_v   [NUM_OUT];
    logic [NUM_OUT-1:0] out_v;

    // Gather per-compare and per-output controls into arrays.
    always_comb begin
        wr_en_v  = {cmpb_wr_en, cmpa_wr_en};
        imm_v    = {cmpb_imm, cmpa_imm};
        wr_d_v[0] = cmpa_wr_data;
        wr_d_v[1] = cmpb_wr_data;
        ld_v[0]  = cmpa_ld_sel;
        ld_v[1]  = cmpb_ld_sel;
        act_v[0] = act_a;
        act_v[1] = act_b;
        frc_v[0] = frc_a;
        frc_v[1] = frc_b;
    end

    assign z_tk = tick & at_zero;
    assign p_tk = tick & at_period;

    // Build the event vector; a compare event needs tick, equality and direction.
    always_comb begin
        evt          = '0;
        evt[EV_ZERO] = z_tk;
        evt[EV_PRD]  = p_tk;
        evt[EV_AUP]  = tick && (cnt == cmp_act[0]) &&  cnt_up;
        evt[EV_ADN]  = tick && (cnt == cmp_act[0]) && !cnt_up;
        evt[EV_BUP]  = tick && (cnt == cmp_act[1]) &&  cnt_up;
        evt[EV_BDN]  = tick && (cnt == cmp_act[1]) && !cnt_up;
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        cmp_reg #(.CNT_W(CNT_W)) i_cmp_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en_v[c]),
            .wr_data   (wr_d_v[c]),
            .imm       (imm_v[c]),
            .ld_sel    (ld_v[c]),
            .ld_zero   (z_tk),
            .ld_period (p_tk),
            .active    (cmp_act[c])
        );
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        aq_chan i_aq_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt),
            .act   (act_v[o]),
            .frc   (frc_v[o]),
            .out   (out_v[o])
        );
    end

    assign pwm_a    = out_v[0];
    assign pwm_b    = out_v[1];
    assign cmpa_cur = cmp_act[0];
    assign cmpb_cur = cmp_act[1];

    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b && cmpa_cur == '0 && cmpb_cur == '0)); // R1
endmodule

// File: tb/test_cmp_aq_unit.sv
`timescale 1ns/1ps
module test_cmp_aq_unit;
    localparam int W = 16;
    logic clk = 0, rst_n = 0;
    logic tick = 0, cnt_up = 0, at_zero = 0, at_period = 0;
    logic [W-1:0] cnt = '0;
    logic cmpa_wr_en = 0, cmpa_imm = 1, cmpb_wr_en = 0, cmpb_imm = 1;
    logic [W-1:0] cmpa_wr_data = '0, cmpb_wr_data = '0;
    logic [1:0] cmpa_ld_sel = 0, cmpb_ld_sel = 0, frc_a = 0, frc_b = 0;
    logic [11:0] act_a = '0, act_b = '0;
    logic pwm_a, pwm_b;
    logic [W-1:0] cmpa_cur, cmpb_cur;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    cmp_aq_unit #(.CNT_W(W)) i_cmp_aq_unit (.*);

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // One tick cycle with the given counter state; inputs drop after the edge.
    task automatic step(input logic tk, input logic [W-1:0] c, input logic up,
                        input logic z, input logic p);
        @(negedge clk);
        tick = tk; cnt = c; cnt_up = up; at_zero = z; at_period = p;
        @(posedge clk); #1;
        tick = 0; at_zero = 0; at_period = 0;
    endtask

    task automatic wr_a(input logic [W-1:0] d);
        @(negedge clk); cmpa_wr_en = 1; cmpa_wr_data = d;
        @(posedge clk); #1; cmpa_wr_en = 0;
    endtask

    task automatic wr_b(input logic [W-1:0] d);
        @(negedge clk); cmpb_wr_en = 1; cmpb_wr_data = d;
        @(posedge clk); #1; cmpb_wr_en = 0;
    endtask

    task automatic t_reset;
        chk("R1 pwm_a", pwm_a, 0); chk("R1 pwm_b", pwm_b, 0);
        chk("R1 cmpa", cmpa_cur, 0); chk("R1 cmpb", cmpb_cur, 0);
    endtask

    task automatic t_codes; // R2 R3: zero=[1:0], period=[3:2]
        act_a = 12'b0000_0000_0110; // zero high, period low
        step(1, 0, 1, 1, 0); chk("R2 zero->high", pwm_a, 1);
        step(1, 50, 0, 0, 1); chk("R3 period->low", pwm_a, 0);
        act_a = 12'b0000_0000_0011; // zero toggle, period hold
        step(1, 0, 1, 1, 0); chk("R2 toggle 1", pwm_a, 1);
        step(1, 50, 0, 0, 1); chk("R2 hold", pwm_a, 1);
        step(1, 0, 1, 1, 0); chk("R2 toggle 2", pwm_a, 0);
    endtask

    task automatic t_no_tick; // R11
        act_a = 12'b0000_0000_0010;
        step(0, 0, 1, 1, 1); chk("R11 no tick output", pwm_a, 0);
        cmpa_imm = 0; cmpa_ld_sel = 2; wr_a(33);
        step(0, 0, 1, 1, 1); chk("R11 no tick reload", cmpa_cur, 0);
        cmpa_imm = 1;
    endtask

    task automatic t_cmp_dir; // R6 R4: A up=[5:4], A down=[7:6]
        wr_a(5); chk("R6 imm write", cmpa_cur, 5);
        act_a = 12'b0000_0110_0000; // A up high, A down low
        step(1, 4, 1, 0, 0); chk("R4 no match", pwm_a, 0);
        step(1, 5, 1, 0, 0); chk("R4 up match", pwm_a, 1);
        step(1, 5, 0, 0, 0); chk("R4 down match", pwm_a, 0);
        step(0, 5, 1, 0, 0); chk("R4 match needs tick", pwm_a, 0);
    endtask

    task automatic t_shadow; // R7
        cmpa_imm = 0; cmpa_ld_sel = 1; wr_a(9);
        chk("R7 shadow held", cmpa_cur, 5);
        step(1, 0, 1, 1, 0); chk("R7 sel1 ignores zero", cmpa_cur, 5);
        step(1, 50, 0, 0, 1); chk("R7 sel1 period", cmpa_cur, 9);
        cmpa_ld_sel = 0; wr_a(7);
        step(1, 50, 0, 0, 1); chk("R7 sel0 ignores period", cmpa_cur, 9);
        step(1, 0, 1, 1, 0); chk("R7 sel0 zero", cmpa_cur, 7);
        cmpa_ld_sel = 2; wr_a(3);
        step(1, 0, 1, 1, 0); chk("R7 sel2 zero", cmpa_cur, 3);
        wr_a(4); step(1, 50, 0, 0, 1); chk("R7 sel2 period", cmpa_cur, 4);
        cmpa_ld_sel = 3; wr_a(8);
        step(1, 0, 1, 1, 0); step(1, 50, 0, 0, 1);
        chk("R7 sel3 never", cmpa_cur, 4);
    endtask

    task automatic t_indep_cmp; // R8
        cmpb_imm = 1; cmpa_ld_sel = 3; wr_b(21); wr_a(11);
        chk("R8 cmpb immediate", cmpb_cur, 21);
        chk("R8 cmpa still shadow", cmpa_cur, 4);
        cmpa_imm = 1; wr_a(10); wr_b(10);
        chk("R8 cmpa imm", cmpa_cur, 10);
    endtask

    task automatic t_priority; // R5: B up=[9:8]
        act_a = 12'b0000_0000_0010; step(1, 0, 1, 1, 0); // pwm_a = 1
        act_a = 12'b0000_0000_0000; act_a[1:0] = 1; act_a[5:4] = 1; act_a[9:8] = 2;
        step(1, 10, 1, 1, 0); chk("R5 B over A and zero", pwm_a, 1);
        act_a[9:8] = 0;
        step(1, 10, 1, 1, 0); chk("R5 B code 0 lets A win", pwm_a, 0);
        act_a = '0; act_a[1:0] = 1; act_a[3:2] = 2;
        step(1, 0, 1, 1, 1); chk("R5 period over zero", pwm_a, 1);
        act_a = '0; act_a[3:2] = 1; act_a[5:4] = 2;
        step(1, 10, 1, 0, 1); chk("R5 A over period", pwm_a, 1);
    endtask

    task automatic t_force; // R9
        act_a = '0; act_a[1:0] = 1; act_a[3:2] = 2;
        frc_a = 1; step(1, 0, 1, 0, 1); chk("R9 force low beats event", pwm_a, 0);
        frc_a = 2; step(1, 0, 1, 1, 0); chk("R9 force high beats event", pwm_a, 1);
        frc_a = 3; step(0, 0, 1, 0, 0); chk("R9 code3 keeps level", pwm_a, 1);
        step(1, 0, 1, 1, 0); chk("R9 code3 events act", pwm_a, 0);
        frc_a = 0; step(1, 50, 0, 0, 1); chk("R9 code0 events act", pwm_a, 1);
    endtask

    task automatic t_chan_b; // R10: B down=[11:10]
        act_a = '0; act_b = '0; act_b[11:10] = 2;
        step(1, 10, 0, 0, 0);
        chk("R10 pwm_b own action", pwm_b, 1); chk("R10 pwm_a untouched", pwm_a, 1);
        frc_b = 1; step(0, 0, 1, 0, 0);
        chk("R10 force b", pwm_b, 0); chk("R10 a unforced", pwm_a, 1);
        frc_b = 0;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; t_reset();
        @(negedge clk); rst_n = 1;
        t_codes(); t_no_tick(); t_cmp_dir(); t_shadow();
        t_indep_cmp(); t_priority(); t_force(); t_chan_b();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule